// File: doc/BRIEF.md
# Circular Storage Block Pointer Tracker

This block follows how full each block of a fixed ring of equal-sized storage blocks is, and keeps two pointers into that ring. The fill pointer names the first block that can still take data. The drain pointer names the block whose contents are currently being read out. Writers add bytes to a numbered block, and a single reader removes bytes from whichever block the drain pointer names. The block capacity in bytes comes in on a port.

A block that reaches capacity is closed and stays closed until the reader has emptied it. Only then does it rejoin the set of open blocks. The open set is kept as one bit per block. A rotated priority search over that bitmap, starting at the current fill pointer, finds the next open block in a single cycle. When every block is closed an overflow flag is raised, and no write can land until a block drains. A write and a read in the same cycle are both applied. Closing, reopening and both pointers are then worked out from the counts that result.

All outputs are registered, so a write or read on the inputs shows up on the outputs right after the next rising clock edge.

Top module: `blockRingTracker`

## Requirements
- R1: After reset every block count is zero, every block is open (fullFlags all 0, emptyFlags all 1), inPtr and outPtr are 0 and overflow is 0.
- R2: The block number of a write is reduced modulo NUM_BLOCKS. For example, with six blocks, number 7 addresses block 1 and number 6 addresses block 0.
- R3: A write is accepted only when its block is open and the block's count plus the write size does not exceed capacity. A rejected write changes no count and no output.
- R4: A block whose count reaches capacity or more after an update becomes closed (its fullFlags bit reads 1). It stays closed, rejecting writes, even after partial reads, until its count returns to zero.
- R5: After each cycle, inPtr names the first open block found by searching upward and wrapping, starting at the current inPtr. It therefore stays put while its own block is open.
- R6: overflow is 1 exactly when no block is open. While overflow is 1, inPtr holds its value. overflow drops in the cycle after a block drains.
- R7: A read removes rdBytes from the count of block outPtr and saturates at zero. A read of a block whose count is already zero has no effect.
- R8: When a read takes the count of block outPtr from non-zero to zero, that block reopens and outPtr advances by one, wrapping from NUM_BLOCKS-1 to 0. outPtr changes in no other case.
- R9: A write and a read in the same cycle are both applied. When both target the drain block, the new count is the old count plus the write minus the read, and closing and draining are judged on that result.
- R10: emptyFlags bit b is 1 exactly when the count of block b is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| capacity | input | CNT_W | Bytes one block can hold (non-zero) |
| wrValid | input | 1 | Write event this cycle |
| wrBlock | input | IDX_W | Target block number, reduced modulo NUM_BLOCKS |
| wrBytes | input | CNT_W | Bytes added by the write |
| rdValid | input | 1 | Read event from the drain block this cycle |
| rdBytes | input | CNT_W | Bytes removed by the read |
| inPtr | output | IDX_W | First open block (fill pointer) |
| outPtr | output | IDX_W | Block being drained |
| fullFlags | output | NUM_BLOCKS | Per-block closed flag |
| emptyFlags | output | NUM_BLOCKS | Per-block zero-count flag |
| overflow | output | 1 | No block is open |

## Verification
The bench builds the block with NUM_BLOCKS = 6 and CNT_W = 12, and drives a capacity of 100. Because six is not a power of two, block numbers 6 and 7 fit in the three-bit field and must wrap to blocks 0 and 1. A ring this small lets the bench fill every block, reach overflow, and run the drain pointer all the way round to block 0 in a few dozen cycles. The sequence then checks reopening, a saturating over-read, a read of an empty block, and a write and a read that land on the drain block in the same cycle.

// File: rtl/blkRingPkg.sv
package blkRingPkg;

  // Strobes issued by the control to the count datapath each cycle.
  typedef struct packed {
    logic wrTake;   // write passed every acceptance test
    logic rdTake;   // read event aimed at the drain block
  } ringStrobe_t;

endpackage

// File: rtl/ringSeek.sv
// Rotated priority search: the first set bit at or after startIdx, wrapping.
module ringSeek #(
  parameter int NUM_BLOCKS = 8,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic [NUM_BLOCKS-1:0] openMask,
  input  logic [IDX_W-1:0]      startIdx,
  output logic                  found,
  output logic [IDX_W-1:0]      hitIdx
);

  always_comb begin
    found  = 1'b0;
    hitIdx = startIdx;
    // Scan the farthest offset first, so the nearest hit is the last write.
    for (int k = NUM_BLOCKS - 1; k >= 0; k--) begin
      int pos;
      pos = int'(startIdx) + k;
      if (pos >= NUM_BLOCKS) pos = pos - NUM_BLOCKS;
      if (openMask[pos]) begin
        found  = 1'b1;
        hitIdx = pos[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/blockCountPath.sv
// Per-block byte counters and the next-state events derived from them.
module blockCountPath
  import blkRingPkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(NUM_BLOCKS),
  localparam int SUM_W = CNT_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ringStrobe_t           strb,
  input  logic [IDX_W-1:0]      wrIdx,
  input  logic [CNT_W-1:0]      wrBytes,
  input  logic [IDX_W-1:0]      rdIdx,
  input  logic [CNT_W-1:0]      rdBytes,
  input  logic [CNT_W-1:0]      capacity,
  output logic                  wrFits,
  output logic [NUM_BLOCKS-1:0] drainVec,
  output logic [NUM_BLOCKS-1:0] atCapVec,
  output logic [NUM_BLOCKS-1:0] emptyFlags
);

  logic [CNT_W-1:0] cnt [NUM_BLOCKS];

  // Fit test uses the count before this cycle's updates.
  always_comb begin
    wrFits = ({1'b0, cnt[wrIdx]} + {1'b0, wrBytes}) <= {1'b0, capacity};
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [SUM_W-1:0] addAmt;
    logic [SUM_W-1:0] subAmt;
    logic [SUM_W-1:0] sumVal;
    logic [SUM_W-1:0] newVal;

    always_comb begin
      addAmt = (strb.wrTake && (wrIdx == IDX_W'(b))) ? {1'b0, wrBytes} : '0;
      subAmt = (strb.rdTake && (rdIdx == IDX_W'(b))) ? {1'b0, rdBytes} : '0;
      sumVal = {1'b0, cnt[b]} + addAmt;
      newVal = (sumVal > subAmt) ? (sumVal - subAmt) : '0;
    end

    assign drainVec[b]   = (subAmt != '0) && (sumVal != '0) && (newVal == '0);
    assign atCapVec[b]   = newVal >= {1'b0, capacity};
    assign emptyFlags[b] = (cnt[b] == '0);

    always_ff @(posedge clk) begin
      if (!rstN) cnt[b] <= '0;
      else       cnt[b] <= newVal[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/ringCtrl.sv
// Open-block bitmap, fill and drain pointers, overflow, and write acceptance.
module ringCtrl
  import blkRingPkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [IDX_W-1:0]      wrBlock,
  input  logic                  rdValid,
  input  logic                  wrFits,
  input  logic [NUM_BLOCKS-1:0] drainVec,
  input  logic [NUM_BLOCKS-1:0] atCapVec,
  output ringStrobe_t           strb,
  output logic [IDX_W-1:0]      wrIdx,
  output logic [NUM_BLOCKS-1:0] openMask,
  output logic [IDX_W-1:0]      inPtr,
  output logic [IDX_W-1:0]      outPtr,
  output logic                  overflow
);

  localparam logic [IDX_W:0]   RING_LEN = (IDX_W+1)'(NUM_BLOCKS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  logic [NUM_BLOCKS-1:0] openNext;
  logic                  seekFound;
  logic [IDX_W-1:0]      seekHit;
  logic [IDX_W:0]        wideBlk;

  // Block number modulo ring length (one subtraction suffices for IDX_W bits).
  always_comb begin
    wideBlk = {1'b0, wrBlock};
    if (wideBlk >= RING_LEN) wideBlk = wideBlk - RING_LEN;
    wrIdx = wideBlk[IDX_W-1:0];
  end

  always_comb begin
    strb.wrTake = wrValid && openMask[wrIdx] && wrFits;
    strb.rdTake = rdValid;
  end

  // Draining reopens a block; reaching capacity closes it.
  always_comb begin
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (drainVec[b])      openNext[b] = 1'b1;
      else if (atCapVec[b]) openNext[b] = 1'b0;
      else                  openNext[b] = openMask[b];
    end
  end

  ringSeek #(.NUM_BLOCKS(NUM_BLOCKS)) u_seek (
    .openMask (openNext),
    .startIdx (inPtr),
    .found    (seekFound),
    .hitIdx   (seekHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openMask <= '1;
      inPtr    <= '0;
      outPtr   <= '0;
      overflow <= 1'b0;
    end else begin
      openMask <= openNext;
      overflow <= !seekFound;
      if (seekFound) inPtr <= seekHit;
      if (|drainVec) outPtr <= (outPtr == LAST_IDX) ? '0 : outPtr + 1'b1;
    end
  end

endmodule

// File: rtl/blockRingTracker.sv
// Thin top: control plus count datapath.
module blockRingTracker
  import blkRingPkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CNT_W-1:0]      capacity,
  input  logic                  wrValid,
  input  logic [IDX_W-1:0]      wrBlock,
  input  logic [CNT_W-1:0]      wrBytes,
  input  logic                  rdValid,
  input  logic [CNT_W-1:0]      rdBytes,
  output logic [IDX_W-1:0]      inPtr,
  output logic [IDX_W-1:0]      outPtr,
  output logic [NUM_BLOCKS-1:0] fullFlags,
  output logic [NUM_BLOCKS-1:0] emptyFlags,
  output logic                  overflow
);

  ringStrobe_t           strb;
  logic [IDX_W-1:0]      wrIdx;
  logic                  wrFits;
  logic [NUM_BLOCKS-1:0] drainVec;
  logic [NUM_BLOCKS-1:0] atCapVec;
  logic [NUM_BLOCKS-1:0] openMask;

  ringCtrl #(.NUM_BLOCKS(NUM_BLOCKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrBlock  (wrBlock),
    .rdValid  (rdValid),
    .wrFits   (wrFits),
    .drainVec (drainVec),
    .atCapVec (atCapVec),
    .strb     (strb),
    .wrIdx    (wrIdx),
    .openMask (openMask),
    .inPtr    (inPtr),
    .outPtr   (outPtr),
    .overflow (overflow)
  );

  blockCountPath #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .wrBytes    (wrBytes),
    .rdIdx      (outPtr),
    .rdBytes    (rdBytes),
    .capacity   (capacity),
    .wrFits     (wrFits),
    .drainVec   (drainVec),
    .atCapVec   (atCapVec),
    .emptyFlags (emptyFlags)
  );

  assign fullFlags = ~openMask;

endmodule

// File: rtl/blockRingTracker_chk.sv
module blockRingTracker_chk #(
  parameter int NUM_BLOCKS = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [CNT_W-1:0]      capacity,
  input logic [IDX_W-1:0]      inPtr,
  input logic [IDX_W-1:0]      outPtr,
  input logic [NUM_BLOCKS-1:0] fullFlags,
  input logic [NUM_BLOCKS-1:0] emptyFlags,
  input logic                  overflow
);

  logic [IDX_W-1:0] prevOut;
  logic [IDX_W-1:0] stepOut;

  always_ff @(posedge clk) begin
    if (!rstN) prevOut <= '0;
    else       prevOut <= outPtr;
  end

  assign stepOut = (prevOut == IDX_W'(NUM_BLOCKS - 1)) ? '0 : prevOut + 1'b1;

  // R6: overflow only when every block is closed
  a_r6_overflow_all_full: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (&fullFlags));

  // R5: without overflow the fill pointer names an open block
  a_r5_inptr_open: assert property (@(posedge clk) disable iff (!rstN)
    !overflow |-> !fullFlags[inPtr]);

  // R4: a closed block is never also empty
  a_r4_full_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    (capacity != '0) |-> ((fullFlags & emptyFlags) == '0));

  // R8: the drain pointer moves only by one step
  a_r8_out_step: assert property (@(posedge clk) disable iff (!rstN)
    (outPtr != prevOut) |-> (outPtr == stepOut));

  // R8: a block left behind by the drain pointer is empty and open
  a_r8_left_block_drained: assert property (@(posedge clk) disable iff (!rstN)
    (outPtr != prevOut) |-> (emptyFlags[prevOut] && !fullFlags[prevOut]));

  // R1: pointers stay inside the ring
  a_r1_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    (int'(inPtr) < NUM_BLOCKS) && (int'(outPtr) < NUM_BLOCKS));

endmodule

bind blockRingTracker blockRingTracker_chk #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .capacity   (capacity),
  .inPtr      (inPtr),
  .outPtr     (outPtr),
  .fullFlags  (fullFlags),
  .emptyFlags (emptyFlags),
  .overflow   (overflow)
);

// File: tb/blockRingTracker_bench.sv
module blockRingTracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 6;
  localparam int CW = 12;
  localparam int IW = $clog2(NB);
  localparam int CAP = 100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] capacity = CW'(CAP);
  logic          wrValid = 1'b0;
  logic [IW-1:0] wrBlock = '0;
  logic [CW-1:0] wrBytes = '0;
  logic          rdValid = 1'b0;
  logic [CW-1:0] rdBytes = '0;
  logic [IW-1:0] inPtr, outPtr;
  logic [NB-1:0] fullFlags, emptyFlags;
  logic          overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  blockRingTracker #(.NUM_BLOCKS(NB), .CNT_W(CW)) u_blockRingTracker (
    .clk(clk), .rstN(rstN), .capacity(capacity),
    .wrValid(wrValid), .wrBlock(wrBlock), .wrBytes(wrBytes),
    .rdValid(rdValid), .rdBytes(rdBytes),
    .inPtr(inPtr), .outPtr(outPtr), .fullFlags(fullFlags),
    .emptyFlags(emptyFlags), .overflow(overflow)
  );

  typedef struct {
    int          inP;
    int          outP;
    logic [NB-1:0] full;
    logic [NB-1:0] empty;
    logic        ovf;
    string       tag;
  } expect_t;

  expect_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // Reference state built from the requirements
  int mCnt[NB];
  bit mOpen[NB];
  int mIn = 0;
  int mOut = 0;
  bit mOvf = 0;

  task automatic compare(expect_t e);
    nChecks++;
    if (inPtr !== IW'(e.inP) || outPtr !== IW'(e.outP) || fullFlags !== e.full ||
        emptyFlags !== e.empty || overflow !== e.ovf) begin
      nFails++;
      $display("FAIL %s: got in=%0d out=%0d full=%b empty=%b ovf=%b, expected in=%0d out=%0d full=%b empty=%b ovf=%b",
               e.tag, inPtr, outPtr, fullFlags, emptyFlags, overflow,
               e.inP, e.outP, e.full, e.empty, e.ovf);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(input bit wv, input int wb, input int wn,
                      input bit rv, input int rn, input string tag);
    expect_t e;
    int blk;
    int nc[NB];
    bit drained;
    bit found;
    @(negedge clk);
    wrValid = wv; wrBlock = IW'(wb); wrBytes = CW'(wn);
    rdValid = rv; rdBytes = CW'(rn);
    blk = (wb >= NB) ? wb - NB : wb;                       // R2
    for (int b = 0; b < NB; b++) nc[b] = mCnt[b];
    if (wv && mOpen[blk] && (mCnt[blk] + wn <= CAP))       // R3
      nc[blk] = nc[blk] + wn;
    drained = 0;
    if (rv && nc[mOut] > 0 && rn > 0) begin                // R7, R9
      nc[mOut] = (nc[mOut] > rn) ? nc[mOut] - rn : 0;
      drained = (nc[mOut] == 0);
    end
    for (int b = 0; b < NB; b++) begin
      if (drained && b == mOut) mOpen[b] = 1;              // R8
      else if (nc[b] >= CAP)    mOpen[b] = 0;              // R4
      mCnt[b] = nc[b];
    end
    found = 0;
    for (int k = 0; k < NB && !found; k++) begin           // R5
      int p;
      p = (mIn + k) % NB;
      if (mOpen[p]) begin found = 1; mIn = p; end
    end
    mOvf = !found;                                         // R6
    if (drained) mOut = (mOut + 1) % NB;
    e.inP = mIn; e.outP = mOut; e.ovf = mOvf; e.tag = tag;
    for (int b = 0; b < NB; b++) begin
      e.full[b]  = !mOpen[b];
      e.empty[b] = (mCnt[b] == 0);                         // R10
    end
    expQ.push_back(e);
  endtask

  // Monitor: compare one expected item per cycle as results appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin mCnt[b] = 0; mOpen[b] = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    begin
      expect_t e;
      e.inP = 0; e.outP = 0; e.full = '0; e.empty = '1; e.ovf = 0;
      e.tag = "R1 reset state";
      compare(e);
    end
    step(1, 0, 60, 0, 0,   "R3 write fits");
    step(1, 0, 50, 0, 0,   "R3 oversize write rejected");
    step(1, 0, 40, 0, 0,   "R4 R5 block 0 closes, fill moves");
    step(1, 7, 100, 0, 0,  "R2 number 7 wraps to block 1");
    step(1, 2, 100, 0, 0,  "R5 fill block 2");
    step(1, 3, 100, 0, 0,  "R5 fill block 3");
    step(1, 4, 100, 0, 0,  "R5 fill block 4");
    step(1, 5, 100, 0, 0,  "R6 all closed, overflow");
    step(1, 2, 10, 0, 0,   "R6 write during overflow rejected");
    step(0, 0, 0, 1, 30,   "R7 R4 partial read keeps block closed");
    step(1, 0, 10, 0, 0,   "R4 write to closed block rejected");
    step(0, 0, 0, 1, 70,   "R8 R6 drain reopens, overflow clears");
    step(1, 0, 20, 1, 100, "R9 write and read in one cycle");
    step(0, 0, 0, 1, 150,  "R7 over-read saturates");
    step(0, 0, 0, 1, 100,  "R8 drain block 3");
    step(0, 0, 0, 1, 100,  "R8 drain block 4");
    step(0, 0, 0, 1, 100,  "R8 drain block 5, pointer wraps");
    step(1, 0, 30, 1, 20,  "R9 write and read on drain block");
    step(0, 0, 0, 1, 30,   "R10 R8 block 0 empties");
    step(0, 0, 0, 1, 5,    "R7 read of empty block ignored");
    step(1, 6, 100, 0, 0,  "R2 R5 number 6 wraps, fill moves on");
    step(0, 0, 0, 0, 0,    "R10 idle cycle holds state");
    @(negedge clk);
    wrValid = 0; rdValid = 0;
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule